// File: doc/BRIEF.md
# Triple Interval Timer

This block holds three independent 16-bit up-counters behind one synchronous register port. Each channel runs free and wraps, or counts in interval mode, where it climbs to a programmed limit, drops back to zero and raises a flag. A power-of-two prescaler can slow each channel's count rate. Pending flags are kept in a status register that clears when it is read. Each flag, masked by an enable register, drives that channel's interrupt line.

Software chooses the mode and divider, loads a limit, and starts the counter by writing the counter-control register with the restart bit set. The registers of the three channels are interleaved: a register of channel c lives at its base offset plus 4*c. Reads are combinational in the cycle that `busRdEn` is high. The clear caused by a status read takes effect at the next clock edge.

Top module: `tri_interval_timer`

## Requirements
- R1: After reset, counter control reads 0x01 (counter held), every other register of every channel reads 0, and `irqOut` is 0.
- R2: Register bases are 0x00 clock control, 0x0C counter control, 0x18 count (read-only), 0x24 interval, 0x54 status (read-only), 0x60 interrupt enable, each at +4 per channel. Clock control keeps bits 4:0, interval keeps bits 15:0, enable keeps bits 1:0. Unmapped offsets read 0.
- R3: While counter-control bit 0 is 1 the count and prescaler hold. The count does not change.
- R4: Writing counter control with bit 4 set zeroes the count and prescaler at that edge. Bit 4 always reads 0. Bit 5 is stored and read back, with no other effect. Bit 1 selects interval mode.
- R5: In free-running mode (bit 1 = 0) the count wraps from 0xFFFF to 0 and sets status bit 1. It never sets status bit 0.
- R6: In interval mode, a tick with the count at or above the interval value loads 0 and sets status bit 0. Any other tick adds one, so the count runs 0..I.
- R7: With clock-control bit 0 set, the count advances once per 2^(N+1) clocks, where N is clock-control bits 4:1. The first tick comes 2^(N+1) clocks after a restart. With bit 0 clear, the count advances every clock.
- R8: A status read returns the pending flags and clears them at the following edge. A flag raised in that same edge is kept.
- R9: `irqOut[c]` is 1 exactly when channel c has a status bit set whose enable bit is also set.
- R10: Writes to the count and status offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe (status clear side effect) |
| busAddr | input | 8 | Byte offset |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data |
| irqOut | output | 3 | Per-channel interrupt |

## Verification
The counting path is exercised with a table of configurations that spreads over the three channels:
- Short and long intervals, including an interval of 0, separate an off-by-one in the restart compare from a correct 0..I sequence.
- Dividers of 1, 2, 4 and 32 show whether the prescaler's first tick and its period are both right.
- A free-running run long enough to wrap tells the overflow flag apart from the interval flag.

Directed cases then cover the hold bit, the self-clearing restart bit, the read-only offsets, clear-on-read, and interrupt masking.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int CNT_W = 16;
  localparam int SEL_W = 4;
  localparam int STS_W = 2;

  localparam int OFF_CLK = 'h00;
  localparam int OFF_CNT = 'h0C;
  localparam int OFF_VAL = 'h18;
  localparam int OFF_INT = 'h24;
  localparam int OFF_STS = 'h54;
  localparam int OFF_IER = 'h60;
  localparam int CH_STRIDE = 4;

  typedef struct packed {
    logic             prescaleEn;
    logic [SEL_W-1:0] prescaleSel;
    logic             hold;
    logic             intervalMode;
    logic [CNT_W-1:0] intervalVal;
  } chanCfg_t;

  typedef struct packed {
    logic cntReset;
    logic statusClr;
  } chanStrobe_t;
endpackage

// File: rtl/tt_regs.sv
module tt_regs
  import tt_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              wrEn,
  input  logic                              rdEn,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wrData,
  output logic [DATA_W-1:0]                 rdData,
  input  logic [NUM_CH-1:0][CNT_W-1:0]      countVal,
  input  logic [NUM_CH-1:0][STS_W-1:0]      statusVal,
  output chanCfg_t [NUM_CH-1:0]             cfgOut,
  output chanStrobe_t [NUM_CH-1:0]          strbOut,
  output logic [NUM_CH-1:0][STS_W-1:0]      ierOut
);
  localparam int CLK_W = SEL_W + 1;

  logic [NUM_CH-1:0][CLK_W-1:0] clkCtrlQ;
  logic [NUM_CH-1:0]            holdQ;
  logic [NUM_CH-1:0]            modeQ;
  logic [NUM_CH-1:0]            outDisQ;
  logic [NUM_CH-1:0][CNT_W-1:0] intervalQ;
  logic [NUM_CH-1:0][STS_W-1:0] ierQ;

  function automatic logic hitAt(input logic [ADDR_W-1:0] a, input int base, input int ch);
    return a == ADDR_W'(base + CH_STRIDE * ch);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkCtrlQ  <= '0;
      holdQ     <= '1;
      modeQ     <= '0;
      outDisQ   <= '0;
      intervalQ <= '0;
      ierQ      <= '0;
    end else if (wrEn) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (hitAt(addr, OFF_CLK, c)) clkCtrlQ[c] <= wrData[CLK_W-1:0];
        if (hitAt(addr, OFF_CNT, c)) begin
          holdQ[c]   <= wrData[0];
          modeQ[c]   <= wrData[1];
          outDisQ[c] <= wrData[5];
        end
        if (hitAt(addr, OFF_INT, c)) intervalQ[c] <= wrData[CNT_W-1:0];
        if (hitAt(addr, OFF_IER, c)) ierQ[c] <= wrData[STS_W-1:0];
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      strbOut[c].cntReset       = wrEn && hitAt(addr, OFF_CNT, c) && wrData[4];
      strbOut[c].statusClr      = rdEn && hitAt(addr, OFF_STS, c);
      cfgOut[c].prescaleEn      = clkCtrlQ[c][0];
      cfgOut[c].prescaleSel     = clkCtrlQ[c][CLK_W-1:1];
      cfgOut[c].hold            = holdQ[c];
      cfgOut[c].intervalMode    = modeQ[c];
      cfgOut[c].intervalVal     = intervalQ[c];
    end
  end

  assign ierOut = ierQ;

  always_comb begin
    rdData = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (hitAt(addr, OFF_CLK, c)) rdData = DATA_W'(clkCtrlQ[c]);
      if (hitAt(addr, OFF_CNT, c)) rdData = DATA_W'({outDisQ[c], 3'b000, modeQ[c], holdQ[c]});
      if (hitAt(addr, OFF_VAL, c)) rdData = DATA_W'(countVal[c]);
      if (hitAt(addr, OFF_INT, c)) rdData = DATA_W'(intervalQ[c]);
      if (hitAt(addr, OFF_STS, c)) rdData = DATA_W'(statusVal[c]);
      if (hitAt(addr, OFF_IER, c)) rdData = DATA_W'(ierQ[c]);
    end
  end

  // R4: restart bit never visible on a counter-control read
  a_r4_no_readback: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && hitAt(addr, OFF_CNT, 0)) |-> !rdData[4]);
endmodule

// File: rtl/tt_channel.sv
module tt_channel
  import tt_pkg::*;
#(
  parameter int WIDTH = CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  chanCfg_t          cfg,
  input  chanStrobe_t       strb,
  output logic [WIDTH-1:0]  count,
  output logic [STS_W-1:0]  status
);
  localparam int PRE_W = (1 << SEL_W) + 1;

  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] preMask;
  logic             preTick, tick, wrapHit, setIntv, setOvf;

  always_comb begin
    preMask = (PRE_W'(1) << ({1'b0, cfg.prescaleSel} + 5'd1)) - PRE_W'(1);
    preTick = !cfg.prescaleEn || ((pre & preMask) == preMask);
    tick    = !cfg.hold && preTick;
    wrapHit = cfg.intervalMode ? (count >= WIDTH'(cfg.intervalVal)) : (count == '1);
    setIntv = tick && wrapHit && cfg.intervalMode && !strb.cntReset;
    setOvf  = tick && wrapHit && !cfg.intervalMode && !strb.cntReset;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count  <= '0;
      pre    <= '0;
      status <= '0;
    end else begin
      if (strb.cntReset) begin
        count <= '0;
        pre   <= '0;
      end else begin
        if (!cfg.hold) pre <= pre + PRE_W'(1);
        if (tick) count <= wrapHit ? '0 : count + WIDTH'(1);
      end
      status <= (status & ~{STS_W{strb.statusClr}}) | {setOvf, setIntv};
    end
  end

  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.hold && !strb.cntReset) |=> count == $past(count));
  a_r4_restart: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntReset |=> count == '0);
  a_r6_interval_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.intervalMode && !cfg.hold && preTick && count >= WIDTH'(cfg.intervalVal) && !strb.cntReset)
      |=> (count == '0) && status[0]);
  a_r5_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.intervalMode && !cfg.hold && preTick && count == '1 && !strb.cntReset)
      |=> (count == '0) && status[1]);
  a_r8_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strb.statusClr && !setIntv && !setOvf) |=> status == '0);
endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
  import tt_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic [NUM_CH-1:0] irqOut
);
  chanCfg_t    [NUM_CH-1:0]            cfg;
  chanStrobe_t [NUM_CH-1:0]            strb;
  logic        [NUM_CH-1:0][CNT_W-1:0] countVal;
  logic        [NUM_CH-1:0][STS_W-1:0] statusVal;
  logic        [NUM_CH-1:0][STS_W-1:0] ier;

  tt_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uRegs (
    .clk(clk), .rstN(rstN), .wrEn(busWrEn), .rdEn(busRdEn), .addr(busAddr),
    .wrData(busWrData), .rdData(busRdData), .countVal(countVal),
    .statusVal(statusVal), .cfgOut(cfg), .strbOut(strb), .ierOut(ier)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : gCh
    tt_channel #(.WIDTH(CNT_W)) uChan (
      .clk(clk), .rstN(rstN), .cfg(cfg[c]), .strb(strb[c]),
      .count(countVal[c]), .status(statusVal[c])
    );
    assign irqOut[c] = |(statusVal[c] & ier[c]);
  end

  // R9: nothing pending means no interrupt
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (statusVal[0] == '0) |-> !irqOut[0]);
endmodule

// File: tb/tri_interval_timer_test.sv
module tri_interval_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;

  logic        clk = 0;
  logic        rstN = 0;
  logic        busWrEn = 0, busRdEn = 0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [2:0]  irqOut;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] rv, rv2;

  tri_interval_timer uut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // clkCtrl, interval, interval mode, wait edges, expected status, expected count
  localparam logic [7:0]  V_CLK [NV] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h09, 8'h09, 8'h00, 8'h03, 8'h00};
  localparam logic [15:0] V_INT [NV] = '{16'd10, 16'd10, 16'd3, 16'd100, 16'd100, 16'd2, 16'd5, 16'd0, 16'd0};
  localparam logic        V_MOD [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam int          V_N   [NV] = '{5, 11, 9, 20, 64, 100, 30, 4, 65536};
  localparam logic [1:0]  V_STS [NV] = '{2'd0, 2'd1, 2'd1, 2'd0, 2'd0, 2'd1, 2'd0, 2'd1, 2'd2};
  localparam logic [15:0] V_CNT [NV] = '{16'd6, 16'd1, 16'd2, 16'd10, 16'd2, 16'd0, 16'd31, 16'd0, 16'd1};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busWrEn = 1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busRdEn = 1; busAddr = a;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    for (int c = 0; c < 3; c++) begin
      logic [7:0] o;
      o = 8'(4 * c);
      rd(8'h0C + o, rv); check("R1 cntCtrl", rv, 32'h1);
      rd(8'h00 + o, rv); check("R1 clkCtrl", rv, 0);
      rd(8'h24 + o, rv); check("R1 interval", rv, 0);
      rd(8'h60 + o, rv); check("R1 ier", rv, 0);
      rd(8'h54 + o, rv); check("R1 status", rv, 0);
      rd(8'h18 + o, rv); check("R1 count", rv, 0);
    end
    #1 check("R1 irq", 32'(irqOut), 0);

    // R2 map, stride and field widths
    wr(8'h04, 32'hFF); rd(8'h04, rv); check("R2 clkCtrl ch1", rv, 32'h1F);
    rd(8'h00, rv); check("R2 clkCtrl ch0 untouched", rv, 0);
    wr(8'h2C, 32'h1234ABCD); rd(8'h2C, rv); check("R2 interval ch2", rv, 32'hABCD);
    rd(8'h24, rv); check("R2 interval ch0 untouched", rv, 0);
    wr(8'h60, 32'hFF); rd(8'h60, rv); check("R2 ier ch0", rv, 32'h3);
    rd(8'h30, rv); check("R2 unmapped", rv, 0);
    wr(8'h60, 0); wr(8'h04, 0);

    // Table: R5 R6 R7 across channels
    for (int i = 0; i < NV; i++) begin
      logic [7:0] o;
      o = 8'(4 * (i % 3));
      wr(8'h0C + o, 32'h1);
      wr(8'h60 + o, 0);
      wr(8'h00 + o, 32'(V_CLK[i]));
      wr(8'h24 + o, 32'(V_INT[i]));
      rd(8'h54 + o, rv);
      wr(8'h0C + o, 32'h10 | (32'(V_MOD[i]) << 1));
      repeat (V_N[i]) @(negedge clk);
      rd(8'h54 + o, rv);
      check($sformatf("R5/R6/R7 vec%0d status", i), rv, 32'(V_STS[i]));
      rd(8'h18 + o, rv);
      check($sformatf("R5/R6/R7 vec%0d count", i), rv, 32'(V_CNT[i]));
    end
    for (int c = 0; c < 3; c++) wr(8'(8'h0C + 4 * c), 32'h1);

    // R3 hold
    wr(8'h00, 0);
    wr(8'h0C, 32'h10);
    repeat (10) @(negedge clk);
    wr(8'h0C, 32'h01);
    rd(8'h18, rv); check("R3 count at hold", rv, 32'd11);
    repeat (5) @(negedge clk);
    rd(8'h18, rv2); check("R3 count still held", rv2, 32'd11);

    // R10 read-only offsets
    rd(8'h54, rv);
    wr(8'h18, 32'h5555); rd(8'h18, rv); check("R10 count write ignored", rv, 32'd11);
    wr(8'h54, 32'h3); rd(8'h54, rv); check("R10 status write ignored", rv, 0);

    // R4 restart bit and stored bit 5
    wr(8'h0C, 32'h33); rd(8'h0C, rv); check("R4 readback", rv, 32'h23);
    rd(8'h18, rv); check("R4 count zeroed", rv, 0);

    // R8 / R9 on channel 1
    wr(8'h10, 32'h1); wr(8'h04, 0); wr(8'h28, 32'd2); wr(8'h64, 32'h1);
    rd(8'h58, rv);
    wr(8'h10, 32'h12);
    repeat (5) @(negedge clk);
    wr(8'h10, 32'h03);
    #1 check("R9 irq ch1 only", 32'(irqOut), 32'b010);
    wr(8'h64, 0);
    #1 check("R9 masked", 32'(irqOut), 0);
    wr(8'h64, 32'h1);
    #1 check("R9 unmasked", 32'(irqOut), 32'b010);
    rd(8'h58, rv); check("R8 first read", rv, 32'h1);
    rd(8'h58, rv); check("R8 cleared", rv, 0);
    #1 check("R9 irq dropped", 32'(irqOut), 0);

    finish_run();
  end
endmodule